// File: doc/BRIEF.md
# Floating-point control register decoder

This block keeps the control word that governs a floating-point unit and turns it into the unit's control signals. Software writes a 64-bit value. Only the upper 32 bits are kept. A read returns the kept word in the upper half of a 64-bit value.

From the kept word the block derives three sets of controls. The first is a five-bit exception-enable vector. The word holds these as disable bits, so the block inverts them and moves them into the order of the status flags. The second is a two-bit rounding-mode code. The third is a pair of denormal controls: one flushes results to zero and one flushes inputs to zero. The decoded controls are registered, so they follow the kept word one clock later. The arithmetic unit, the gathering of status flags and the delivery of traps are outside this block.

Top module: `fpcr_ctrl`

## Requirements
- R1: On a rising edge with `wr_en_i` high, bits [63:32] of `wr_data_i` become the stored word, and bits [31:0] are discarded. When `wr_en_i` is low the stored word keeps its value.
- R2: `rd_data_o` is combinational. It carries the stored word in bits [63:32], and bits [31:0] are always zero.
- R3: `exc_en_o[k]` is the inverse of one disable bit of the stored word. Bit 0 (invalid) uses word bit 17, bit 1 (divide-by-zero) uses bit 18, bit 2 (overflow) uses bit 19, bit 3 (underflow) uses bit 13, and bit 4 (inexact) uses bit 30. Vector bits 0 to 4 line up with the status flags at word bits 20 to 24.
- R4: The rounding field is word bits [27:26], and `rnd_mode_o` decodes it as follows:
  - field 00 (normal) gives 2'b00, round to nearest even.
  - field 01 (chopped) gives 2'b11, round toward zero.
  - field 10 (minus) gives 2'b01, round toward minus infinity.
  - field 11 (plus) gives 2'b10, round toward plus infinity.
  
  Any other field value falls back to 2'b00.
- R5: `flush_res_o` is high only when word bit 13 (underflow disable) and word bit 28 (underflow to zero) are both set.
- R6: `flush_in_o` follows word bit 16 (denormal to zero) alone.
- R7: The decoded outputs change on the rising edge after the edge that stores a write. Between those two edges they still reflect the previous word.
- R8: Asynchronous reset clears the stored word. After reset `rd_data_o` is 0, `exc_en_o` is 5'b11111, `rnd_mode_o` is 2'b00, and both flush outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write data; upper half kept |
| rd_data_o | output | 64 | Stored word in upper half, zeros below |
| exc_en_o | output | 5 | Exception enables: inexact, underflow, overflow, divide-by-zero, invalid (MSB to LSB) |
| rnd_mode_o | output | 2 | Decoded rounding mode |
| flush_res_o | output | 1 | Flush denormal results to zero |
| flush_in_o | output | 1 | Flush denormal inputs to zero |

## Verification
A read and a write can fall in the same cycle, and so can a write and a decoded-output update from the write before it. The bench provokes both with back-to-back writes and with reads sampled in the cycle of a write.

It judges them against a per-cycle model:
- The read must still show the old word until the write's edge.
- The decoded outputs must lag the read port by exactly one edge.
- Each field of every output is compared on every cycle.

// File: rtl/fpcr_pkg.sv
package fpcr_pkg;
  localparam int BUS_W  = 64;
  localparam int WORD_W = BUS_W / 2;
  localparam int N_EXC  = 5;

  // disable-bit positions, in exception-enable vector order
  localparam int DIS_POS [N_EXC] = '{17, 18, 19, 13, 30};
  localparam int RND_LO  = 26;
  localparam int UNF_ZERO = 28;
  localparam int UNF_DIS  = 13;
  localparam int DNZ_BIT  = 16;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_DOWN    = 2'b01,
    RND_UP      = 2'b10,
    RND_ZERO    = 2'b11
  } rnd_e;

  typedef struct packed {
    logic [N_EXC-1:0] exc_en;
    rnd_e             rnd;
    logic             flush_res;
    logic             flush_in;
  } ctrl_t;
endpackage

// File: rtl/fpcr_store.sv
module fpcr_store
  import fpcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (wr_en_i) word_o <= wr_data_i[BUS_W-1:WORD_W];
  end

  p_wr_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> word_o == $past(wr_data_i[BUS_W-1:WORD_W]));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(word_o));
endmodule

// File: rtl/fpcr_decode.sv
module fpcr_decode
  import fpcr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output ctrl_t             ctrl_o
);
  logic [N_EXC-1:0] en;

  for (genvar k = 0; k < N_EXC; k++) begin : g_en
    assign en[k] = ~word_i[DIS_POS[k]];
  end

  always_comb begin
    ctrl_o.exc_en    = en;
    unique case (word_i[RND_LO+:2])
      2'b00:   ctrl_o.rnd = RND_NEAREST;
      2'b01:   ctrl_o.rnd = RND_ZERO;
      2'b10:   ctrl_o.rnd = RND_DOWN;
      2'b11:   ctrl_o.rnd = RND_UP;
      default: ctrl_o.rnd = RND_NEAREST;
    endcase
    ctrl_o.flush_res = word_i[UNF_DIS] & word_i[UNF_ZERO];
    ctrl_o.flush_in  = word_i[DNZ_BIT];
  end
endmodule

// File: rtl/fpcr_ctrl.sv
module fpcr_ctrl
  import fpcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic [N_EXC-1:0]  exc_en_o,
  output logic [1:0]        rnd_mode_o,
  output logic              flush_res_o,
  output logic              flush_in_o
);
  logic [WORD_W-1:0] word;
  ctrl_t             ctrl_d, ctrl_q;

  fpcr_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .word_o   (word)
  );

  fpcr_decode u_decode (
    .word_i(word),
    .ctrl_o(ctrl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '{exc_en: '1, rnd: RND_NEAREST, flush_res: 1'b0, flush_in: 1'b0};
    else         ctrl_q <= ctrl_d;
  end

  assign rd_data_o   = {word, {WORD_W{1'b0}}};
  assign exc_en_o    = ctrl_q.exc_en;
  assign rnd_mode_o  = ctrl_q.rnd;
  assign flush_res_o = ctrl_q.flush_res;
  assign flush_in_o  = ctrl_q.flush_in;

  p_rd_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == {$past(wr_data_i[BUS_W-1:WORD_W]), {WORD_W{1'b0}}});
  p_inv_dis_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word[DIS_POS[0]] |=> !exc_en_o[0]);
  p_unf_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word[UNF_DIS] |=> exc_en_o[3]);
  p_rnd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word[RND_LO+:2] == 2'b01) |=> rnd_mode_o == 2'b11);
  p_ftz_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_res_o |-> $past(word[UNF_DIS] && word[UNF_ZERO]));
  p_dnz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word[DNZ_BIT] |=> flush_in_o);
  p_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && $stable(word) |=> $stable(exc_en_o) && $stable(rnd_mode_o));
endmodule

// File: tb/fpcr_ctrl_tb.sv
module fpcr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [4:0]  exc_en;
  logic [1:0]  rnd;
  logic        ftz_res, ftz_in;

  int vectors = 0;
  int errors  = 0;
  bit done = 1'b0;

  logic [31:0] m_word = '0;
  logic [4:0]  m_en = 5'h1f;
  logic [1:0]  m_rnd = 2'b00;
  logic        m_fr = 1'b0, m_fi = 1'b0;

  always #5 clk = ~clk;

  fpcr_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .exc_en_o(exc_en), .rnd_mode_o(rnd),
    .flush_res_o(ftz_res), .flush_in_o(ftz_in)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1/R2 read", rd_data, {m_word, 32'h0});
    chk("R3 enables", {59'h0, exc_en}, {59'h0, m_en});
    chk("R4 rounding", {62'h0, rnd}, {62'h0, m_rnd});
    chk("R5 flush result", {63'h0, ftz_res}, {63'h0, m_fr});
    chk("R6 flush input", {63'h0, ftz_in}, {63'h0, m_fi});
  endtask

  // one cycle: compare at negedge, drive, advance model after edge (R7 lag)
  task automatic step(input logic we, input logic [63:0] d);
    @(negedge clk);
    compare_all();
    wr_en = we;
    wr_data = d;
    @(posedge clk);
    #1;
    m_en[0] = ~m_word[17];
    m_en[1] = ~m_word[18];
    m_en[2] = ~m_word[19];
    m_en[3] = ~m_word[13];
    m_en[4] = ~m_word[30];
    case (m_word[27:26])
      2'b00: m_rnd = 2'b00;
      2'b01: m_rnd = 2'b11;
      2'b10: m_rnd = 2'b01;
      default: m_rnd = 2'b10;
    endcase
    m_fr = m_word[13] & m_word[28];
    m_fi = m_word[16];
    if (we) m_word = d[63:32];
  endtask

  function automatic logic [63:0] hi(input logic [31:0] w);
    return {w, 32'hdead_beef};
  endfunction

  initial begin
    #23 rst_n = 1'b1;
    // R8 reset state
    @(negedge clk);
    chk("R8 reset read", rd_data, 64'h0);
    chk("R8 reset enables", {59'h0, exc_en}, 64'h1f);
    chk("R8 reset rounding", {62'h0, rnd}, 64'h0);
    chk("R8 reset flush", {62'h0, ftz_res, ftz_in}, 64'h0);
    // R4 every rounding field, back to back (R7 overlap)
    for (int f = 0; f < 4; f++) step(1'b1, hi(32'(f) << 26));
    // R3 each disable bit alone
    step(1'b1, hi(32'h1 << 17));
    step(1'b1, hi(32'h1 << 18));
    step(1'b1, hi(32'h1 << 19));
    step(1'b1, hi(32'h1 << 13));
    step(1'b1, hi(32'h1 << 30));
    // R5 each half alone, then both
    step(1'b1, hi(32'h1 << 28));
    step(1'b1, hi(32'h1 << 13));
    step(1'b1, hi((32'h1 << 13) | (32'h1 << 28)));
    // R6 denormal-to-zero
    step(1'b1, hi(32'h1 << 16));
    // R1 low half discarded, idle cycles hold
    step(1'b1, 64'h0000_0000_ffff_ffff);
    step(1'b1, 64'hffff_ffff_0000_0000);
    for (int i = 0; i < 4; i++) step(1'b0, 64'h1234_5678_9abc_def0);
    for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 1)), {$urandom, $urandom});
    step(1'b0, 64'h0);
    step(1'b0, 64'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule